// File: doc/BRIEF.md
# Snooping Cache Coherence Controller

This block keeps a set of private caches coherent over one shared bus. Every cache has its own controller and its own tag/state store. Each store holds a second copy of the tags that only the bus side reads, so a snoop lookup never competes with the processor lookup. Processors raise a line request with an address and a read/write flag. A hit that needs no coherence action finishes locally. Any other request goes to a round-robin arbiter, which grants one bus transaction per cycle.

Line states are Invalid, Shared and Modified. A static mode input selects the write policy. In invalidate mode a write removes every other copy and leaves the writer in Modified. In update mode a write is broadcast, every holder keeps its copy in Shared, and memory is written through. On a miss, a remote Modified copy supplies the line. A second static input chooses whether that copy is pushed back to memory first or sent straight to the requesting cache, and the owner then drops to Shared. The store is direct-mapped, and only tags and states are modelled; data arrays and memory timing are left to the surrounding logic. The bus outputs report the transaction that was granted, the caches that snooped a match, memory writes, direct transfers and victim write-backs. A probe port reads any cache's state for a given address.

Top module: `coh_snoop_fabric`

## Requirements
- R1: After reset every line of every cache reads as Invalid (state code 0) on the probe port. `bus_valid`, `req_done`, `snoop_hit`, `mem_wr`, `c2c_xfer` and `evict_wb` are all 0 when the bus is idle.
- R2: A read that misses is granted on the bus with `bus_cmd`=1, the request address on `bus_addr` and the requester index on `bus_src`. The requester's `req_done` pulses in that same registered cycle, and the requester's line becomes Shared.
- R3: A read that hits in Shared or Modified, and a write that hits in Modified, finish with a `req_done` pulse one cycle later without any bus transaction. The line state does not change.
- R4: With `update_mode`=0, a write that misses or hits Shared issues `bus_cmd`=2. Every other cache holding the line, flagged in `snoop_hit`, goes to Invalid, and the writer goes to Modified.
- R5: With `update_mode`=1, a write that is not a Modified hit issues `bus_cmd`=3 with `mem_wr`=1. Other holders, flagged in `snoop_hit`, end in Shared, and the writer installs the line in Shared.
- R6: When a bus request finds a remote Modified copy and `direct_xfer`=0, `mem_wr`=1 and `c2c_xfer`=0. The owner goes to Shared on a read (`bus_cmd`=1) or an update (`bus_cmd`=3), and to Invalid on an invalidating write (`bus_cmd`=2).
- R7: In the same situation with `direct_xfer`=1, `c2c_xfer`=1. `mem_wr` is 1 only for an update (`bus_cmd`=3). The owner's new state follows the rules of R6.
- R8: The arbiter grants at most one cache per cycle. Among pending bus requests it picks the first one after the previously granted index, wrapping round. The first grant after reset goes to the lowest index. A request that is not granted stays pending.
- R9: A bus request whose own line at that index holds a different tag in Modified raises `evict_wb`=1 with the transaction.
- R10: `probe_state` shows the state of `probe_addr` in cache `probe_cpu` one cycle after the probe inputs are applied: 0 Invalid, 1 Shared, 2 Modified. A tag mismatch reads as 0.
- R11: `req_done` is a one-cycle pulse. A request still held in the cycle its done is high is not served again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| update_mode | input | 1 | 1 = write-update policy, 0 = write-invalidate |
| direct_xfer | input | 1 | 1 = owner sends the line cache-to-cache, 0 = owner writes back to memory |
| req_valid | input | NCPU | Per-cache request, held until done |
| req_write | input | NCPU | Per-cache write flag |
| req_addr | input | NCPU*AW | Per-cache line address, cache i in bits [i*AW +: AW] |
| req_done | output | NCPU | One-cycle completion pulse per cache |
| bus_valid | output | 1 | A transaction was granted |
| bus_cmd | output | 2 | 1 read, 2 invalidating write, 3 update write |
| bus_addr | output | AW | Transaction address |
| bus_src | output | SRCW | Granted cache index |
| snoop_hit | output | NCPU | Caches other than the source that held the line |
| mem_wr | output | 1 | Memory write (write-through or owner write-back) |
| c2c_xfer | output | 1 | Owner supplies the line directly |
| evict_wb | output | 1 | Requester's Modified victim is written back |
| probe_cpu | input | SRCW | Cache to inspect |
| probe_addr | input | AW | Address to inspect |
| probe_state | output | 2 | Registered state of the probed line |

## Verification
Every result of this block is due one clock edge after its cause. A granted or local request shows its `req_done` pulse and bus outputs one edge after the request is applied, and the stores are written at that same edge. A probe result appears one edge after the probe inputs. The bench applies inputs on the falling edge and checks on the next falling edge, which is exactly one rising edge later. It then checks again one edge after that, to confirm the pulse has ended and the bus is idle. When several requests are pending, each following falling edge is expected to show exactly one grant, in the rotation order predicted from the last index granted.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_M = 2'd2
  } line_st_t;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_INV  = 2'd2,
    CMD_UPD  = 2'd3
  } bus_cmd_t;
endpackage

// File: rtl/coh_rr_arb.sv
module coh_rr_arb #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_vld
);
  logic [IW-1:0] last;

  always_comb begin
    int cand;
    gnt     = '0;
    gnt_idx = '0;
    gnt_vld = 1'b0;
    for (int k = 1; k <= N; k++) begin
      cand = int'(last) + k;
      if (cand >= N) cand = cand - N;
      if (!gnt_vld && req[cand]) begin
        gnt_vld    = 1'b1;
        gnt_idx    = IW'(cand);
        gnt[cand]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last <= IW'(N - 1);
    else if (gnt_vld) last <= gnt_idx;
  end

  assert_onehot_grant_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));
  assert_grant_to_requester_R8: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~req) == '0);
  assert_pending_gets_grant_R8: assert property (@(posedge clk) disable iff (rst)
    (|req) |-> gnt_vld);
endmodule

// File: rtl/coh_tag_store.sv
module coh_tag_store
  import coh_pkg::*;
#(
  parameter int IDXW = 4,
  parameter int TAGW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [IDXW-1:0] widx,
  input  logic [TAGW-1:0] wtag,
  input  line_st_t        wst,
  input  logic [IDXW-1:0] p_idx,
  output logic [TAGW-1:0] p_tag,
  output line_st_t        p_st,
  input  logic [IDXW-1:0] q_idx,
  output logic [TAGW-1:0] q_tag,
  output line_st_t        q_st,
  input  logic [IDXW-1:0] s_idx,
  output logic [TAGW-1:0] s_tag,
  output line_st_t        s_st
);
  localparam int SETS = 1 << IDXW;

  // processor-side copy and bus-side (snoop) copy, written together
  logic [TAGW-1:0] ptag [SETS];
  logic [TAGW-1:0] stag [SETS];
  line_st_t        pst  [SETS];
  line_st_t        sst  [SETS];

  always_ff @(posedge clk) begin
    if (we) begin
      ptag[widx] <= wtag;
      stag[widx] <= wtag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SETS; i++) begin
        pst[i] <= ST_I;
        sst[i] <= ST_I;
      end
    end else if (we) begin
      pst[widx] <= wst;
      sst[widx] <= wst;
    end
  end

  assign p_tag = ptag[p_idx];
  assign p_st  = pst[p_idx];
  assign q_tag = ptag[q_idx];
  assign q_st  = pst[q_idx];
  assign s_tag = stag[s_idx];
  assign s_st  = sst[s_idx];

  assert_write_state_legal_R10: assert property (@(posedge clk) disable iff (rst)
    we |-> (wst != 2'd3));
endmodule

// File: rtl/coh_snoop_fabric.sv
module coh_snoop_fabric
  import coh_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int AW   = 8,
  parameter int IDXW = 4,
  parameter int SRCW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 update_mode,
  input  logic                 direct_xfer,
  input  logic [NCPU-1:0]      req_valid,
  input  logic [NCPU-1:0]      req_write,
  input  logic [NCPU*AW-1:0]   req_addr,
  output logic [NCPU-1:0]      req_done,
  output logic                 bus_valid,
  output logic [1:0]           bus_cmd,
  output logic [AW-1:0]        bus_addr,
  output logic [SRCW-1:0]      bus_src,
  output logic [NCPU-1:0]      snoop_hit,
  output logic                 mem_wr,
  output logic                 c2c_xfer,
  output logic                 evict_wb,
  input  logic [SRCW-1:0]      probe_cpu,
  input  logic [AW-1:0]        probe_addr,
  output logic [1:0]           probe_state
);
  localparam int TAGW = AW - IDXW;

  logic [AW-1:0]   a_addr [NCPU];
  logic [TAGW-1:0] p_tag  [NCPU];
  logic [TAGW-1:0] q_tag  [NCPU];
  logic [TAGW-1:0] s_tag  [NCPU];
  line_st_t        p_st   [NCPU];
  line_st_t        q_st   [NCPU];
  line_st_t        s_st   [NCPU];
  line_st_t        wr_st  [NCPU];
  logic [NCPU-1:0] hit, elig, local_ok, need_bus, snp, s_m, wr_en, gnt;
  logic [SRCW-1:0] g;
  logic            gnt_vld;
  logic [AW-1:0]   g_addr;
  logic [IDXW-1:0] g_idx;
  logic [TAGW-1:0] g_tag;
  bus_cmd_t        cmd;
  logic            owner_m, victim_m;

  coh_rr_arb #(.N(NCPU), .IW(SRCW)) u_arb (
    .clk(clk), .rst(rst), .req(need_bus),
    .gnt(gnt), .gnt_idx(g), .gnt_vld(gnt_vld)
  );

  assign g_addr = a_addr[g];
  assign g_idx  = g_addr[IDXW-1:0];
  assign g_tag  = g_addr[AW-1:IDXW];
  assign cmd    = !req_write[g] ? CMD_RD : (update_mode ? CMD_UPD : CMD_INV);

  for (genvar i = 0; i < NCPU; i++) begin : g_cache
    assign a_addr[i] = req_addr[i*AW +: AW];

    coh_tag_store #(.IDXW(IDXW), .TAGW(TAGW)) u_store (
      .clk(clk), .rst(rst),
      .we(wr_en[i]), .widx(g_idx), .wtag(g_tag), .wst(wr_st[i]),
      .p_idx(a_addr[i][IDXW-1:0]), .p_tag(p_tag[i]), .p_st(p_st[i]),
      .q_idx(probe_addr[IDXW-1:0]), .q_tag(q_tag[i]), .q_st(q_st[i]),
      .s_idx(g_idx), .s_tag(s_tag[i]), .s_st(s_st[i])
    );

    assign hit[i]      = (p_st[i] != ST_I) && (p_tag[i] == a_addr[i][AW-1:IDXW]);
    assign elig[i]     = req_valid[i] && !req_done[i];
    assign local_ok[i] = elig[i] && hit[i] && (!req_write[i] || p_st[i] == ST_M);
    assign need_bus[i] = elig[i] && !local_ok[i];
    assign snp[i]      = gnt_vld && (g != SRCW'(i)) && (s_st[i] != ST_I) &&
                         (s_tag[i] == g_tag);
    assign s_m[i]      = snp[i] && (s_st[i] == ST_M);
    assign wr_en[i]    = gnt_vld && ((g == SRCW'(i)) || snp[i]);
    assign wr_st[i]    = (g == SRCW'(i)) ? ((cmd == CMD_INV) ? ST_M : ST_S)
                                         : ((cmd == CMD_INV) ? ST_I : ST_S);
  end

  assign owner_m  = |s_m;
  assign victim_m = (p_st[g] == ST_M) && (p_tag[g] != g_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_done    <= '0;
      bus_valid   <= 1'b0;
      bus_cmd     <= CMD_NONE;
      bus_addr    <= '0;
      bus_src     <= '0;
      snoop_hit   <= '0;
      mem_wr      <= 1'b0;
      c2c_xfer    <= 1'b0;
      evict_wb    <= 1'b0;
      probe_state <= ST_I;
    end else begin
      req_done  <= local_ok | gnt;
      bus_valid <= gnt_vld;
      bus_cmd   <= gnt_vld ? cmd : CMD_NONE;
      bus_addr  <= gnt_vld ? g_addr : '0;
      bus_src   <= gnt_vld ? g : '0;
      snoop_hit <= snp;
      mem_wr    <= gnt_vld && ((cmd == CMD_UPD) || (owner_m && !direct_xfer));
      c2c_xfer  <= gnt_vld && owner_m && direct_xfer;
      evict_wb  <= gnt_vld && victim_m;
      probe_state <= (q_tag[probe_cpu] == probe_addr[AW-1:IDXW]) ? q_st[probe_cpu]
                                                                 : ST_I;
    end
  end

  assert_idle_bus_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |-> (snoop_hit == '0 && !mem_wr && !c2c_xfer && !evict_wb));
  assert_bus_src_done_R2: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> req_done[bus_src]);
  assert_source_not_snooped_R4: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> !snoop_hit[bus_src]);
  assert_update_writes_mem_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_cmd == CMD_UPD) |-> mem_wr);
  assert_direct_needs_owner_R7: assert property (@(posedge clk) disable iff (rst)
    c2c_xfer |-> (bus_valid && snoop_hit != '0));
  assert_done_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    (req_done & $past(req_done)) == '0);
endmodule

// File: tb/coh_snoop_fabric_test.sv
module coh_snoop_fabric_test;
  localparam int NCPU = 4;
  localparam int AW   = 8;
  localparam int IDXW = 4;
  localparam int SRCW = 2;
  localparam int SETS = 1 << IDXW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic update_mode = 1'b0, direct_xfer = 1'b0;
  logic [NCPU-1:0] req_valid = '0, req_write = '0;
  logic [NCPU*AW-1:0] req_addr = '0;
  logic [NCPU-1:0] req_done, snoop_hit;
  logic bus_valid, mem_wr, c2c_xfer, evict_wb;
  logic [1:0] bus_cmd, probe_state;
  logic [AW-1:0] bus_addr;
  logic [SRCW-1:0] bus_src;
  logic [SRCW-1:0] probe_cpu = '0;
  logic [AW-1:0] probe_addr = '0;

  always #10 clk = ~clk;

  coh_snoop_fabric #(.NCPU(NCPU), .AW(AW), .IDXW(IDXW), .SRCW(SRCW)) uut (
    .clk(clk), .rst(rst), .update_mode(update_mode), .direct_xfer(direct_xfer),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_done(req_done), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_src(bus_src), .snoop_hit(snoop_hit),
    .mem_wr(mem_wr), .c2c_xfer(c2c_xfer), .evict_wb(evict_wb),
    .probe_cpu(probe_cpu), .probe_addr(probe_addr), .probe_state(probe_state)
  );

  int total = 0, bad = 0;
  int exp_st [NCPU][SETS];
  int exp_tag[NCPU][SETS];
  int last_g = NCPU - 1;
  bit finished = 0;

  task automatic chk(string rq, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int model_probe(int c, int addr);
    int ix = addr % SETS;
    if (exp_st[c][ix] != 0 && exp_tag[c][ix] == addr / SETS) return exp_st[c][ix];
    return 0;
  endfunction

  task automatic probe_all(int addr, string rq);
    for (int p = 0; p < NCPU; p++) begin
      @(negedge clk);
      probe_cpu  = SRCW'(p);
      probe_addr = AW'(addr);
      @(negedge clk);
      chk(rq, int'(probe_state), model_probe(p, addr));
    end
  endtask

  // one request from cache c, expected results from the model
  task automatic do_op(int c, int addr, bit w, bit um, bit dx);
    int ix = addr % SETS;
    int tg = addr / SETS;
    bit hitc = exp_st[c][ix] != 0 && exp_tag[c][ix] == tg;
    bit loc  = hitc && (!w || exp_st[c][ix] == 2);
    int e_cmd = 0, e_hit = 0;
    bit owner = 0, e_mem = 0, e_c2c = 0, e_ev = 0;
    @(negedge clk);
    update_mode = um; direct_xfer = dx;
    req_valid[c] = 1'b1; req_write[c] = w;
    req_addr[c*AW +: AW] = AW'(addr);
    if (!loc) begin
      e_cmd = !w ? 1 : (um ? 3 : 2);
      for (int j = 0; j < NCPU; j++)
        if (j != c && exp_st[j][ix] != 0 && exp_tag[j][ix] == tg) begin
          e_hit |= (1 << j);
          if (exp_st[j][ix] == 2) owner = 1;
        end
      e_mem = (e_cmd == 3) || (owner && !dx);
      e_c2c = owner && dx;
      e_ev  = exp_st[c][ix] == 2 && exp_tag[c][ix] != tg;
      for (int j = 0; j < NCPU; j++)
        if (e_hit[j]) exp_st[j][ix] = (e_cmd == 2) ? 0 : 1;
      exp_st[c][ix] = (e_cmd == 2) ? 2 : 1;
      exp_tag[c][ix] = tg;
      last_g = c;
    end
    @(negedge clk);
    chk(loc ? "R3 done" : "R2 done", int'(req_done), 1 << c);
    chk(loc ? "R3 no bus" : "R2 bus valid", int'(bus_valid), loc ? 0 : 1);
    if (!loc) begin
      chk("R2 cmd", int'(bus_cmd), e_cmd);
      chk("R2 addr", int'(bus_addr), addr);
      chk("R2 src", int'(bus_src), c);
      chk(e_cmd == 3 ? "R5 snoop hits" : "R4 snoop hits", int'(snoop_hit), e_hit);
      chk(owner ? "R6 mem write" : "R5 mem write", int'(mem_wr), int'(e_mem));
      chk("R7 direct xfer", int'(c2c_xfer), int'(e_c2c));
      chk("R9 evict", int'(evict_wb), int'(e_ev));
    end
    req_valid[c] = 1'b0;
    @(negedge clk);
    chk("R11 done ends", int'(req_done), 0);
    chk("R1 bus idle", int'(bus_valid), 0);
    probe_all(addr, "R10 probe");
  endtask

  // several caches ask at once; expected rotation from last_g
  task automatic rr_round(int mask, int ix, int tg);
    int pend = mask;
    @(negedge clk);
    update_mode = 0; direct_xfer = 0;
    for (int c = 0; c < NCPU; c++)
      if (mask[c]) begin
        req_valid[c] = 1'b1; req_write[c] = 1'b0;
        req_addr[c*AW +: AW] = AW'(tg * SETS + ix + c);
      end
    while (pend != 0) begin
      int e = last_g;
      for (int k = 1; k <= NCPU; k++) begin
        int cand = (last_g + k) % NCPU;
        if (pend[cand]) begin e = cand; break; end
      end
      @(negedge clk);
      chk("R8 rotation grant", int'(req_done), 1 << e);
      chk("R8 rotation src", int'(bus_src), e);
      chk("R2 read cmd", int'(bus_cmd), 1);
      req_valid[e] = 1'b0;
      exp_st[e][ix + e] = 1; exp_tag[e][ix + e] = tg;
      pend &= ~(1 << e);
      last_g = e;
    end
    @(negedge clk);
    chk("R11 no repeat", int'(req_done), 0);
  endtask

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCPU; c++)
      for (int s = 0; s < SETS; s++) begin exp_st[c][s] = 0; exp_tag[c][s] = 0; end
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 done reset", int'(req_done), 0);
    chk("R1 bus reset", int'(bus_valid), 0);
    probe_all(0, "R1 invalid after reset");
    probe_all(5, "R1 invalid after reset");

    // R8: first rotation starts at cache 0
    rr_round(4'b1111, 8, 15);
    rr_round(4'b1011, 8, 14);
    rr_round(4'b0110, 8, 13);

    // directed: R4 then R7 direct supply, owner to Shared
    do_op(0, 16 + 1, 1, 0, 0);
    do_op(1, 16 + 1, 0, 0, 1);
    // R3 hits: read Shared, write Modified
    do_op(1, 16 + 1, 0, 0, 0);
    do_op(0, 16 + 2, 1, 0, 0);
    do_op(0, 16 + 2, 1, 0, 0);
    // R6 write-back supply
    do_op(2, 16 + 2, 0, 0, 0);
    // R5 update keeps sharers
    do_op(3, 16 + 2, 1, 1, 0);
    // R9 eviction of Modified victim
    do_op(3, 3, 1, 0, 0);
    do_op(3, 16 + 3, 0, 0, 0);

    for (int n = 0; n < 300; n++) begin
      int c  = $urandom_range(NCPU - 1);
      int ad = $urandom_range(1) * SETS + $urandom_range(3);
      do_op(c, ad, 1'($urandom_range(1)), 1'($urandom_range(1)),
            1'($urandom_range(1)));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule